// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block is a bus slave that lets a host reach a large video memory and a register file through one small address window. The host first loads a 32-bit pointer register. Later accesses to a 4-byte data window are then forwarded. When bit 31 of the pointer is set, the access goes to a byte-addressed memory port. When bit 31 is clear, the access goes back into the block's own register space.

Every access carries a size code for 1, 2 or 4 bytes. Data on the bus is right-justified and little-endian. A partial access at byte lane k reads or writes only the bytes from bit 8k upward. Memory accesses are bounds-checked against the memory size, and an access that fails the check is dropped without any side effect. Register space also holds a small bank of scratch registers and a read-only window that mirrors configuration words. A select input maps the whole register space onto a small alias aperture.

Top module: `ixwin`

## Requirements
- R1: After reset the pointer register and every scratch register read as 0. No read response is pending and no memory request is made.
- R2: The pointer register sits at offset 0x000. All 32 bits can be read and written, with byte-lane merging on partial writes.
- R3: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. A read at lane k = address[1:0] returns (word >> 8k) masked to the size. A write changes only the lanes from k up to k+size-1. Bytes that would fall past lane 3 are discarded.
- R4: When pointer bit 31 is set, any access to the data window at 0x004–0x007 goes to memory at byte address P = pointer[30:0]. The request uses word address P[..:2] and byte enables equal to the size mask shifted left by P[1:0]. Write data is shifted left by 8·P[1:0]. Read data is extracted from lane P[1:0].
- R5: The memory request is issued only if P + size ≤ MEM_BYTES and P[1:0] + size ≤ 4. Otherwise no request is made, a write has no effect and a read returns 0.
- R6: When pointer bit 31 is clear, a window access at byte k is handled as a register access at offset pointer + k, with the same size and data.
- R7: If that indirect offset is below 8 or at or above the 0x4000-byte aperture, reads return 0 and writes are dropped.
- R8: Scratch register i sits at offset 0x010 + 4i (NUM_SCR of them) and can be read and written.
- R9: Offsets 0xF00–0xFFF are read-only. 0xF00 reads CFG_ID, 0xF04 reads CFG_CLASS, and every other word reads 0. Writes there change nothing. Any other unmapped offset reads 0.
- R10: When io_sel is high, only address bits 7:0 are used, so the alias aperture maps onto the first 0x100 bytes.
- R11: Every read returns bus_rvalid with data exactly one cycle after the request. A write never produces bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_io_sel | input | 1 | Access arrives through the alias aperture |
| bus_addr | input | REG_AW | Byte offset in register space |
| bus_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Right-justified read data |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write |
| mem_waddr | output | MEM_AW-2 | Memory word address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Lane-aligned memory write data |
| mem_rvalid | input | 1 | Memory read data valid, one cycle after the request |
| mem_rdata | input | 32 | Memory read word |

## Verification
Most faults show up one cycle after the access that exposes them. A corrupted pointer register sends the next window access to the wrong memory word or register, so the wrong data appears on bus_rdata in the response cycle. A bad bounds or lane decision shows at once as a mem_req that should not be there, or a missing one, in the same cycle as bus_req. A lost write only becomes visible at the next read of the same location, which the random mix reaches within a few operations.

// File: rtl/ixwin.sv
module ixwin #(
  parameter int          REG_AW      = 14,
  parameter int          MEM_BYTES   = 4096,
  parameter int          NUM_SCR     = 4,
  parameter int          SCR_BASE    = 'h010,
  parameter int          CFG_BASE    = 'hF00,
  parameter int          ALIAS_BYTES = 256,
  parameter logic [31:0] CFG_ID      = 32'h5A17_00C3,
  parameter logic [31:0] CFG_CLASS   = 32'h0300_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_io_sel,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [$clog2(MEM_BYTES)-3:0] mem_waddr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  localparam int MEM_AW     = $clog2(MEM_BYTES);
  localparam int APER_BYTES = 1 << REG_AW;
  localparam int ALIAS_AW   = $clog2(ALIAS_BYTES);
  localparam int WORD_AW    = REG_AW - 2;
  localparam int SCR_W      = SCR_BASE / 4;
  localparam int CFG_W      = CFG_BASE / 4;
  localparam int CFG_WORDS  = 64;
  localparam int SCR_IW     = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1;

  function automatic logic [31:0] size_mask(input logic [2:0] n);
    return (n == 3'd1) ? 32'h0000_00FF : (n == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] lane_get(input logic [31:0] w, input logic [1:0] l,
                                           input logic [2:0] n);
    return (w >> (8 * l)) & size_mask(n);
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] l,
                                           input logic [2:0] n, input logic [31:0] d);
    logic [31:0] m;
    m = size_mask(n) << (8 * l);
    return (w & ~m) | ((d << (8 * l)) & m);
  endfunction

  logic [31:0] idx_q;
  logic [31:0] scr_q [NUM_SCR];
  logic        rvalid_q, memrd_q;
  logic [1:0]  lane_q;
  logic [2:0]  nb_q;
  logic [31:0] rd_q;

  logic [REG_AW-1:0] a;
  logic [2:0]        nb;
  logic              in_win, mem_sel, mem_ok, ind_bad, reg_ok;
  logic [32:0]       mem_end, ind_t;
  logic [REG_AW-1:0] reg_t;
  logic [WORD_AW-1:0] rword;
  logic [1:0]        rlane;
  logic              scr_hit, cfg_hit;
  logic [WORD_AW-1:0] scr_off, cfg_off;
  logic [31:0]       reg_word;

  assign a       = bus_io_sel ? REG_AW'(bus_addr[ALIAS_AW-1:0]) : bus_addr;
  assign nb      = (bus_size == 2'd0) ? 3'd1 : (bus_size == 2'd1) ? 3'd2 : 3'd4;
  assign in_win  = (a[REG_AW-1:2] == WORD_AW'(1));
  assign mem_sel = in_win & idx_q[31];
  assign mem_end = {2'b00, idx_q[30:0]} + 33'(nb);
  assign mem_ok  = (mem_end <= 33'(MEM_BYTES)) && ((3'(idx_q[1:0]) + nb) <= 3'd4);
  assign ind_t   = {1'b0, idx_q} + 33'(a[1:0]);
  assign ind_bad = (ind_t < 33'd8) || (ind_t >= 33'(APER_BYTES));
  assign reg_t   = in_win ? ind_t[REG_AW-1:0] : a;
  assign reg_ok  = !in_win || (!idx_q[31] && !ind_bad);
  assign rword   = reg_t[REG_AW-1:2];
  assign rlane   = reg_t[1:0];

  assign scr_off = rword - WORD_AW'(SCR_W);
  assign cfg_off = rword - WORD_AW'(CFG_W);
  assign scr_hit = (rword >= WORD_AW'(SCR_W)) && (rword < WORD_AW'(SCR_W + NUM_SCR));
  assign cfg_hit = (rword >= WORD_AW'(CFG_W)) && (rword < WORD_AW'(CFG_W + CFG_WORDS));

  always_comb begin
    reg_word = 32'h0;
    if (rword == '0)  reg_word = idx_q;
    else if (scr_hit) reg_word = scr_q[scr_off[SCR_IW-1:0]];
    else if (cfg_hit) reg_word = (cfg_off == '0) ? CFG_ID :
                                 (cfg_off == WORD_AW'(1)) ? CFG_CLASS : 32'h0;
  end

  assign mem_req   = bus_req & mem_sel & mem_ok;
  assign mem_we    = bus_we;
  assign mem_waddr = idx_q[MEM_AW-1:2];
  assign mem_be    = ((nb == 3'd1) ? 4'b0001 : (nb == 3'd2) ? 4'b0011 : 4'b1111) << idx_q[1:0];
  assign mem_wdata = bus_wdata << (8 * idx_q[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < NUM_SCR; i++) scr_q[i] <= '0;
    end else if (bus_req && bus_we && !mem_sel && reg_ok) begin
      if (rword == '0) idx_q <= lane_put(idx_q, rlane, nb, bus_wdata);
      for (int i = 0; i < NUM_SCR; i++)
        if (scr_hit && scr_off[SCR_IW-1:0] == SCR_IW'(i))
          scr_q[i] <= lane_put(scr_q[i], rlane, nb, bus_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      memrd_q  <= 1'b0;
      lane_q   <= '0;
      nb_q     <= 3'd4;
      rd_q     <= '0;
    end else begin
      rvalid_q <= bus_req & ~bus_we;
      memrd_q  <= bus_req & ~bus_we & mem_sel & mem_ok;
      lane_q   <= idx_q[1:0];
      nb_q     <= nb;
      rd_q     <= (bus_req && !bus_we && !mem_sel && reg_ok) ? lane_get(reg_word, rlane, nb) : 32'h0;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = memrd_q ? (mem_rvalid ? lane_get(mem_rdata, lane_q, nb_q) : 32'h0) : rd_q;
endmodule

module ixwin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic       bus_rvalid,
  input logic       mem_req,
  input logic       mem_we,
  input logic [3:0] mem_be
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !bus_rvalid);

  assert_read_answers_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  assert_no_stray_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we));

  assert_mem_follows_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (bus_req && (mem_we == bus_we)));

  assert_mem_be_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  assert_mem_read_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> bus_rvalid);
endmodule

bind ixwin ixwin_chk u_chk (.*);

// File: tb/ixwin_bench.sv
module ixwin_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 4096;
  localparam int MEM_WORDS  = MEM_BYTES / 4;
  localparam int NUM_SCR    = 4;
  localparam logic [31:0] CFG_ID    = 32'h5A17_00C3;
  localparam logic [31:0] CFG_CLASS = 32'h0300_0001;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, bus_io_sel = 0;
  logic [13:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid, mem_req, mem_we;
  logic [31:0] bus_rdata, mem_wdata;
  logic [9:0]  mem_waddr;
  logic [3:0]  mem_be;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] bmem [MEM_WORDS];
  logic [31:0] m_mem [MEM_WORDS];
  logic [31:0] m_idx;
  logic [31:0] m_scr [NUM_SCR];

  ixwin u_ixwin (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_we;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_waddr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= bmem[mem_waddr];
    end
  end

  function automatic logic [31:0] msk(input int n);
    return (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] getl(input logic [31:0] w, input int l, input int n);
    return (w >> (8*l)) & msk(n);
  endfunction
  function automatic logic [31:0] putl(input logic [31:0] w, input int l, input int n,
                                       input logic [31:0] d);
    logic [31:0] m;
    m = msk(n) << (8*l);
    return (w & ~m) | ((d << (8*l)) & m);
  endfunction
  function automatic logic [31:0] regword(input int w);
    if (w == 0) return m_idx;
    if (w >= 4 && w < 4 + NUM_SCR) return m_scr[w-4];
    if (w == 'h3C0) return CFG_ID;
    if (w == 'h3C1) return CFG_CLASS;
    return 32'h0;
  endfunction

  task automatic reg_model(input bit we, input int t, input int n, input logic [31:0] wd,
                           output logic [31:0] exp);
    int w = t >> 2, l = t & 3;
    exp = we ? 32'h0 : getl(regword(w), l, n);
    if (we) begin
      if (w == 0) m_idx = putl(m_idx, l, n, wd);
      else if (w >= 4 && w < 4 + NUM_SCR) m_scr[w-4] = putl(m_scr[w-4], l, n, wd);
    end
  endtask

  task automatic model(input bit we, input bit io, input logic [13:0] addr, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] exp, output bit emr);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    int a = io ? int'(addr[7:0]) : int'(addr);
    longint p, t;
    exp = 0; emr = 0;
    if (a >= 4 && a < 8) begin
      if (m_idx[31]) begin
        p = longint'(m_idx[30:0]);
        if (p + n <= MEM_BYTES && (p % 4) + n <= 4) begin
          emr = 1;
          if (we) m_mem[p/4] = putl(m_mem[p/4], int'(p % 4), n, wd);
          else exp = getl(m_mem[p/4], int'(p % 4), n);
        end
      end else begin
        t = longint'(m_idx) + (a - 4);
        if (t >= 8 && t < 'h4000) reg_model(we, int'(t), n, wd, exp);
      end
    end else reg_model(we, a, n, wd, exp);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input bit we, input bit io, input logic [13:0] addr,
                    input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] exp;
    bit emr, seen;
    model(we, io, addr, sz, wd, exp, emr);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_io_sel = io; bus_addr = addr; bus_size = sz; bus_wdata = wd;
    #1 seen = mem_req;
    @(negedge clk);
    bus_req = 0;
    check({req, " R11 valid"}, 32'(bus_rvalid), 32'(!we));
    if (!we) check({req, " data"}, bus_rdata, exp);
    if (addr[13:2] == 1 || (io && addr[7:2] == 1)) check({req, " R5 mem_req"}, 32'(seen), 32'(emr));
  endtask

  task automatic setp(input logic [31:0] v);
    op("R2 ptr", 1, 0, 14'h000, 2'd2, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2741));
    for (int i = 0; i < MEM_WORDS; i++) begin
      bmem[i] = 32'h9E37_79B9 * (i + 1);
      m_mem[i] = bmem[i];
    end
    m_idx = 0;
    for (int i = 0; i < NUM_SCR; i++) m_scr[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 rvalid", 32'(bus_rvalid), 0);
    rst_n = 1;
    op("R1 ptr", 0, 0, 14'h000, 2'd2, 0);
    op("R1 scratch", 0, 0, 14'h014, 2'd2, 0);
    op("R2 byte", 1, 0, 14'h002, 2'd0, 32'hAB);
    op("R2 half", 0, 0, 14'h001, 2'd1, 0);
    op("R3 size3", 1, 0, 14'h010, 2'd3, 32'hDEAD_BEEF);
    op("R3 lane3 half", 1, 0, 14'h013, 2'd1, 32'h1234);
    op("R8 scratch", 0, 0, 14'h010, 2'd2, 0);
    op("R9 cfg write", 1, 0, 14'hF00, 2'd2, 32'h0);
    op("R9 cfg id", 0, 0, 14'hF00, 2'd2, 0);
    op("R9 cfg class", 0, 0, 14'hF05, 2'd1, 0);
    op("R9 unmapped", 0, 0, 14'h2000, 2'd2, 0);
    setp(32'h8000_0000 | (MEM_BYTES - 4));
    op("R4 top word", 1, 0, 14'h004, 2'd2, 32'hCAFE_F00D);
    op("R4 top read", 0, 0, 14'h006, 2'd2, 0);
    setp(32'h8000_0000 | (MEM_BYTES - 3));
    op("R5 past end", 0, 0, 14'h004, 2'd2, 0);
    op("R5 past end w", 1, 0, 14'h004, 2'd2, 32'h1);
    op("R4 last bytes", 0, 0, 14'h005, 2'd1, 0);
    setp(32'h8000_0007);
    op("R5 cross", 0, 0, 14'h004, 2'd1, 0);
    op("R4 lane3", 0, 0, 14'h004, 2'd0, 0);
    setp(32'h0000_0000);
    op("R7 self", 0, 0, 14'h004, 2'd2, 0);
    op("R7 self w", 1, 0, 14'h007, 2'd0, 32'h55);
    op("R7 ptr kept", 0, 0, 14'h000, 2'd2, 0);
    setp(32'h0000_3FFD);
    op("R7 over top", 0, 0, 14'h007, 2'd0, 0);
    op("R6 under top", 0, 0, 14'h006, 2'd0, 0);
    setp(32'h0000_0010);
    op("R6 ind write", 1, 0, 14'h005, 2'd1, 32'h7788);
    op("R6 ind read", 0, 0, 14'h004, 2'd2, 0);
    op("R10 alias", 0, 1, 14'h2A04, 2'd2, 0);
    op("R10 alias ptr", 0, 1, 14'h1100, 2'd2, 0);

    for (int it = 0; it < 800; it++) begin
      int r = $urandom % 10;
      if (r < 2) begin
        case ($urandom % 4)
          0: v = 32'h8000_0000 | ($urandom % (MEM_BYTES + 8));
          1: v = 32'h8000_0000 | (MEM_BYTES - 1 - ($urandom % 8));
          2: v = 32'h0000_0008 + ($urandom % 24);
          default: v = ($urandom % 2) ? (32'hF00 + ($urandom % 8)) : (32'h3FF8 + ($urandom % 16));
        endcase
        setp(v);
      end else begin
        logic [13:0] ad;
        bit io = ($urandom % 4 == 0);
        case ($urandom % 4)
          0, 1: ad = 14'h004 + 14'($urandom % 4);
          2: ad = 14'h010 + 14'($urandom % 20);
          default: ad = ($urandom % 2) ? 14'($urandom % 8) : (14'hF00 + 14'($urandom % 12));
        endcase
        if (io) ad = {6'($urandom), ad[7:0]};
        op("R3 random", $urandom % 2, io, ad, 2'($urandom), $urandom);
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule